// File: doc/BRIEF.md
# Periodic Battery Health Tester

This block decides when a backup cell is put under a test load and what the battery warning output says. A free-running prescaler supplies a one-cycle `tick`, typically one per second. While the power sequencer holds `mon_en` high, the block counts ticks. After each full test interval it raises `load_en` for a short load window. On the last tick of that window it takes the comparator's "below threshold" verdict from `bat_low`. The analog load, the comparator and the open-drain pad driver are outside the block.

A failed sample latches an active-low warning. Once latched, scheduled tests stop, so the warning stays until the next power-up. A `pwr_up` pulse always requests a test, even when the warning is already latched. If that power-up test passes, the warning is released and scheduled testing starts again.

All control and status pins are plain level or pulse signals. No stream interface is involved, so the block has no valid/ready handshake and no back-pressure. `INTERVAL_TICKS` and `LOAD_TICKS` set the time constants, counted in ticks.

Top module: `bt_health_tester`

## Requirements
- R1: During and directly after reset, `load_en` is 0 and `warn_n` is 1, whatever was latched before.
- R2: A `pwr_up` pulse while `mon_en` is 1 and no window is open raises `load_en` at the next clock edge. `load_en` stays 1 until the edge that sees the `LOAD_TICKS`-th tick after the window opened, and drops at that edge.
- R3: A `pwr_up` pulse while `mon_en` is 0 is remembered. The power-up window opens at the first edge where `mon_en` is 1.
- R4: `bat_low` is judged only at the edge of the last tick of a window. A 1 there drives `warn_n` to 0 at that edge. A value of `bat_low` at any other time has no effect on `warn_n`.
- R5: While no warning is latched and nothing is pending, ticks are counted from the end of the previous test, or from the start of the last power-up test. The edge of the `INTERVAL_TICKS`-th counted tick opens a scheduled window.
- R6: A passing scheduled test leaves `warn_n` unchanged. While `warn_n` is 0, no scheduled window opens.
- R7: A passing power-up test drives `warn_n` to 1. Scheduled testing then resumes, with the interval counted from that test's end.
- R8: While `mon_en` is 0, `load_en` is 0 in the same cycle. An open window is abandoned without a judgement, and interval counting is paused, not reset.
- R9: A power-up window that is abandoned because `mon_en` fell is opened again once `mon_en` returns to 1.
- R10: A `pwr_up` in the same cycle as the interval expiry tick opens exactly one window, of the power-up kind. A `pwr_up` during an open window opens a second, power-up window one cycle after the first one closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_en | input | 1 | Monitoring allowed; supply is good and the write-protect delay has elapsed |
| pwr_up | input | 1 | One-cycle power-up event |
| tick | input | 1 | One-cycle prescaler tick |
| bat_low | input | 1 | Comparator verdict, 1 = battery below trip point |
| load_en | output | 1 | Connects the test load while 1 |
| warn_n | output | 1 | Battery warning, active low |

## Verification
Two functions can land in the same cycle: a power-up request, and the tick that ends the test interval. The bench drives `pwr_up` together with the expiry tick. It then checks that exactly one window opens, and that no second window follows once that window closes. A full interval is needed before the next scheduled window, which shows that the power-up test reset the interval. A second case overlaps a power-up request with a window that is already open. For that case the bench requires a closed gap of exactly one cycle before the follow-up window.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic {
    KIND_PERIODIC = 1'b0,
    KIND_POWERUP  = 1'b1
  } kind_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bt_interval_timer.sv
module bt_interval_timer #(
  parameter int INTERVAL_TICKS = 86400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic due
);
  localparam int W = bt_pkg::cnt_width(INTERVAL_TICKS);
  localparam logic [W-1:0] LAST = W'(INTERVAL_TICKS - 1);

  logic [W-1:0] cnt_q;

  assign due = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= due ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bt_load_window.sv
module bt_load_window #(
  parameter int LOAD_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic tick,
  output logic active,
  output logic done
);
  localparam int W = bt_pkg::cnt_width(LOAD_TICKS);
  localparam logic [W-1:0] LAST = W'(LOAD_TICKS - 1);

  logic [W-1:0] cnt_q;
  logic         act_q;

  assign active = act_q;
  assign done   = act_q && !abort && tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && tick) begin
      if (done) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bt_warn_latch.sv
module bt_warn_latch (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          judge,
  input  logic          fail,
  input  bt_pkg::kind_e kind,
  output logic          warn
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn <= 1'b0;
    end else if (judge) begin
      if (fail) begin
        warn <= 1'b1;
      end else if (kind == bt_pkg::KIND_POWERUP) begin
        warn <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bt_health_tester.sv
module bt_health_tester #(
  parameter int INTERVAL_TICKS = 86400,
  parameter int LOAD_TICKS     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic pwr_up,
  input  logic tick,
  input  logic bat_low,
  output logic load_en,
  output logic warn_n
);
  import bt_pkg::*;

  logic  active, done, due, warn;
  logic  pend_q;
  kind_e kind_q;
  logic  can_start, start_pu, start_per, abort, run, clr;

  assign abort     = active && !mon_en;
  assign can_start = mon_en && !active;
  assign start_pu  = can_start && (pend_q || pwr_up);
  assign start_per = can_start && !start_pu && due;
  assign run       = can_start && !warn && !pend_q && !pwr_up;
  assign clr       = start_pu || done;

  bt_interval_timer #(.INTERVAL_TICKS(INTERVAL_TICKS)) ivl_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .tick(tick), .due(due)
  );

  bt_load_window #(.LOAD_TICKS(LOAD_TICKS)) win_i (
    .clk(clk), .rst_n(rst_n), .start(start_pu || start_per), .abort(abort),
    .tick(tick), .active(active), .done(done)
  );

  bt_warn_latch warn_i (
    .clk(clk), .rst_n(rst_n), .judge(done), .fail(bat_low), .kind(kind_q),
    .warn(warn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= KIND_PERIODIC;
    end else begin
      pend_q <= (pend_q || pwr_up || (abort && kind_q == KIND_POWERUP)) && !start_pu;
      if (start_pu) begin
        kind_q <= KIND_POWERUP;
      end else if (start_per) begin
        kind_q <= KIND_PERIODIC;
      end
    end
  end

  assign load_en = active && mon_en;
  assign warn_n  = !warn;
endmodule

// File: rtl/bt_health_checker.sv
module bt_health_checker (
  input logic          clk,
  input logic          rst_n,
  input logic          mon_en,
  input logic          tick,
  input logic          bat_low,
  input logic          load_en,
  input logic          warn_n,
  input bt_pkg::kind_e kind_q
);
  AST_WARN_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n) (warn_n != $past(warn_n)) |-> ($past(load_en) && $past(tick))); // R4
  AST_SET_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n) ($past(load_en) && !load_en && mon_en && $past(tick) && $past(bat_low)) |-> !warn_n); // R4
  AST_PASS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) ($past(load_en) && !load_en && mon_en && $past(tick) && !$past(bat_low)) |-> !$fell(warn_n)); // R6
  AST_NO_SCHED_WHILE_WARN: assert property (@(posedge clk) disable iff (!rst_n) ($rose(load_en) && !$past(warn_n)) |-> (kind_q == bt_pkg::KIND_POWERUP)); // R6
  AST_CLEAR_BY_POWERUP: assert property (@(posedge clk) disable iff (!rst_n) $rose(warn_n) |-> (kind_q == bt_pkg::KIND_POWERUP)); // R7
endmodule

bind bt_health_tester bt_health_checker chk_i (
  .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .tick(tick), .bat_low(bat_low),
  .load_en(load_en), .warn_n(warn_n), .kind_q(kind_q)
);

// File: tb/bt_health_tester_tb.sv
module bt_health_tester_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_en = 1'b0, pwr_up = 1'b0, tick = 1'b0, bat_low = 1'b0;
  logic load_en, warn_n;
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bt_health_tester #(.INTERVAL_TICKS(4), .LOAD_TICKS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .pwr_up(pwr_up), .tick(tick),
    .bat_low(bat_low), .load_en(load_en), .warn_n(warn_n)
  );

  // vector: {pwr_up, mon_en, tick, bat_low, exp load_en, exp warn_n, req}
  function automatic logic [9:0] mkv(bit pu, bit mon, bit tk, bit bat, bit ld, bit wn, logic [3:0] rq);
    return {pu, mon, tk, bat, ld, wn, rq};
  endfunction

  localparam int NV = 35;
  localparam logic [9:0] VEC [NV] = '{
    mkv(1,1,0,0, 1,1, 2),  // R2 power-up window opens
    mkv(0,1,1,1, 1,1, 4),  // R4 bat_low before last tick ignored
    mkv(0,1,1,0, 0,1, 2),  // R2 window closes on 2nd tick
    mkv(0,1,1,0, 0,1, 5),  // R5 count 1
    mkv(0,1,0,1, 0,1, 4),  // R4 bat_low outside window ignored
    mkv(0,1,1,0, 0,1, 5),  // R5 count 2
    mkv(0,1,1,0, 0,1, 5),  // R5 count 3
    mkv(0,1,1,0, 1,1, 5),  // R5 scheduled window
    mkv(0,1,1,0, 1,1, 5),
    mkv(0,1,1,1, 0,0, 4),  // R4 fail latches warning
    mkv(0,1,1,0, 0,0, 6),  // R6 no scheduled window while warned
    mkv(0,1,1,0, 0,0, 6),
    mkv(0,1,1,0, 0,0, 6),
    mkv(0,1,1,0, 0,0, 6),
    mkv(0,1,1,0, 0,0, 6),
    mkv(0,1,1,0, 0,0, 6),
    mkv(0,0,1,1, 0,0, 8),  // R8
    mkv(1,0,0,0, 0,0, 3),  // R3 request while supply bad
    mkv(0,0,1,0, 0,0, 3),  // R3 still deferred
    mkv(0,1,0,0, 1,0, 3),  // R3 opens once mon_en returns
    mkv(0,1,1,0, 1,0, 7),
    mkv(0,1,1,0, 0,1, 7),  // R7 pass clears warning
    mkv(0,1,1,0, 0,1, 7),  // R7 schedule resumes
    mkv(0,1,1,0, 0,1, 7),
    mkv(0,1,1,0, 0,1, 7),
    mkv(0,1,1,0, 1,1, 7),  // R7 scheduled window again
    mkv(0,1,1,0, 1,1, 6),
    mkv(0,1,1,0, 0,1, 6),  // R6 scheduled pass leaves warn_n
    mkv(1,1,0,0, 1,1, 2),
    mkv(0,1,1,0, 1,1, 8),
    mkv(0,0,1,1, 0,1, 8),  // R8 abandoned, no judgement
    mkv(0,0,0,0, 0,1, 9),  // R9
    mkv(0,1,0,0, 1,1, 9),  // R9 rerun power-up window
    mkv(0,1,1,1, 1,1, 9),
    mkv(0,1,1,1, 0,0, 9)   // R9 rerun judged
  };

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b", rq, what, act, exp);
    end
  endtask

  task automatic cyc(input logic pu, input logic mon, input logic tk, input logic bat);
    pwr_up = pu; mon_en = mon; tick = tk; bat_low = bat;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "load_en in reset", load_en, 1'b0);
    chk("R1", "warn_n in reset", warn_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "load_en after reset", load_en, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
      chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), "load_en", load_en, VEC[i][5]);
      chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), "warn_n", warn_n, VEC[i][4]);
    end

    // R1: reset releases a latched warning
    rst_n = 1'b0; pwr_up = 0; tick = 0; bat_low = 0;
    @(negedge clk);
    chk("R1", "warn_n on reset", warn_n, 1'b1);
    chk("R1", "load_en on reset", load_en, 1'b0);
    rst_n = 1'b1;

    // R10: power-up coincides with the interval expiry tick
    cyc(1,1,0,0); chk("R2", "load_en", load_en, 1'b1);
    cyc(0,1,1,0); cyc(0,1,1,0); chk("R2", "load_en closed", load_en, 1'b0);
    for (int k = 0; k < 3; k++) cyc(0,1,1,0);
    chk("R5", "no window before expiry", load_en, 1'b0);
    cyc(1,1,1,0); chk("R10", "one window on coincidence", load_en, 1'b1);
    cyc(0,1,1,0); cyc(0,1,1,0); chk("R10", "window closed", load_en, 1'b0);
    cyc(0,1,0,0); chk("R10", "no second window", load_en, 1'b0);
    cyc(0,1,0,0); chk("R10", "no second window", load_en, 1'b0);
    for (int k = 0; k < 3; k++) cyc(0,1,1,0);
    chk("R5", "interval restarted", load_en, 1'b0);
    cyc(0,1,1,0); chk("R5", "scheduled after full interval", load_en, 1'b1);
    cyc(0,1,1,0); cyc(0,1,1,0); chk("R6", "pass keeps warn_n", warn_n, 1'b1);

    // R10: power-up during an open window
    cyc(1,1,0,0); chk("R10", "first window", load_en, 1'b1);
    cyc(1,1,0,0); cyc(0,1,1,0); cyc(0,1,1,0);
    chk("R10", "gap after first window", load_en, 1'b0);
    cyc(0,1,0,0); chk("R10", "follow-up window", load_en, 1'b1);
    // R8: load_en drops in the same cycle as mon_en
    mon_en = 1'b0; pwr_up = 1'b0; tick = 1'b0;
    #1; chk("R8", "load_en same cycle", load_en, 1'b0);
    @(negedge clk);
    cyc(0,1,0,0); chk("R9", "abandoned power-up rerun", load_en, 1'b1);
    cyc(0,1,1,1); cyc(0,1,1,1); chk("R4", "fail latches", warn_n, 1'b0);
    cyc(1,1,0,0); cyc(0,1,1,0); cyc(0,1,1,0);
    chk("R7", "power-up pass clears", warn_n, 1'b1);

    // R8: interval counting paused, not reset
    cyc(0,1,1,0); cyc(0,1,1,0);
    for (int k = 0; k < 5; k++) cyc(0,0,1,0);
    chk("R8", "no window while mon_en low", load_en, 1'b0);
    cyc(0,1,1,0); chk("R8", "count resumed at 3", load_en, 1'b0);
    cyc(0,1,1,0); chk("R8", "window after paused count", load_en, 1'b1);
    cyc(0,1,1,0); cyc(0,1,1,0); cyc(0,1,0,0);
    chk("R6", "warn_n after scheduled pass", warn_n, 1'b1);

    summary();
  end
endmodule